// File: doc/BRIEF.md
# Time-Multiplexed Lookup-Table Evaluation Engine

This block is a single computing element. It evaluates a wide Boolean function over several clock cycles by reusing one table memory, not by building the function in one spatial pass. The function is cut into small partitions ahead of time. Each partition is a multi-input, multi-output lookup table held in its own region of an internal memory. A sequencer visits the partitions in order. For each partition, an address-forming network picks each table address bit from either the captured primary inputs or the intermediate bits that earlier partitions left in a temporary register file. The table word that is read back is written into one slice of that register file, so later partitions can use it.

The element is used in two phases. First, while the engine is idle, software or a loader writes table rows and one configuration word per step through a configuration port. Then a start pulse captures the inputs and runs the steps. A one-cycle done pulse marks the result, which appears on the output port.

Top module: `lut_eval_engine`

## Requirements
- R1: After reset, `done` is 0, `dout` is 0 and the engine is idle, so the next `start` is accepted.
- R2: A `start` accepted in idle captures `din` and clears all temporary bits. The result of a run therefore never depends on an earlier run.
- R3: Each step takes two cycles: address, then write-back. Counting the rising edge that samples `start` as the first, `done` is seen high after rising edge 2*S+1, where S is the number of steps executed.
- R4: `done` is high for exactly one cycle per evaluation.
- R5: The 4-bit source code for an address bit has these meanings. Code c in 0..3 selects captured input bit c. Code c in 4..11 selects temporary bit c-4. Codes 12..15 give a constant 0.
- R6: The step word is laid out as follows. Bits [4j+3:4j] hold the source code for table address bit j (j = 0..5). Bit 24 is the last-step flag. Bit 25 picks the destination slice: 0 for temporary bits 3..0, 1 for temporary bits 7..4. The table row read in step k is k*64 + address.
- R7: A write-back replaces only the selected 4-bit slice. The other slice keeps its value.
- R8: Evaluation ends after the step whose last flag is set. If no step sets the flag, it ends after step 7 (8 steps).
- R9: `dout` equals temporary bits 3..0. It holds the result after `done` until the next accepted `start`.
- R10: Configuration writes are ignored unless the engine is idle.
- R11: A `start` pulse during an evaluation is ignored. It changes neither the captured inputs, the timing nor the result.
- R12: `cfg_sel` = 0 writes table row `cfg_addr` (9 bits) with `cfg_data[3:0]`. `cfg_sel` = 1 writes the step word with index `cfg_addr[2:0]` with `cfg_data[25:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = table row, 1 = step word |
| cfg_addr | input | 9 | Table row address or step index |
| cfg_data | input | 26 | Table row value or step word |
| start | input | 1 | Start an evaluation (idle only) |
| din | input | 4 | Primary inputs |
| done | output | 1 | One-cycle completion pulse |
| dout | output | 4 | Low temporary slice (result) |

## Verification
The bench builds the engine with its default parameters: 4 inputs, 8 temporary bits, 6-bit step addresses, 4-bit rows and 8 steps. With these values, the three loaded decompositions reach every source code class, both destination slices, the constant-zero codes and the 8-step limit without a last flag. Table rows whose unused address bits are nonzero hold deliberately wrong values, so a routing fault shows up in the result. Randomly placed start pulses and step-word writes during a run check that a busy engine ignores both.

// File: rtl/lut_pkg.sv
package lut_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ADDR  = 2'd1,
      ST_WRITE = 2'd2,
      ST_DONE  = 2'd3
   } eng_state_t;

   localparam logic CFG_TABLE = 1'b0;
   localparam logic CFG_STEP  = 1'b1;
endpackage

// File: rtl/lut_table_mem.sv
module lut_table_mem #(
   parameter int DATA_W = 4,
   parameter int DEPTH  = 512,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   if (DEPTH < 2) begin : g_bad_depth
      $error("lut_table_mem: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/lut_step_store.sv
module lut_step_store #(
   parameter int WORD_W  = 26,
   parameter int N_STEPS = 8,
   localparam int IDX_W  = $clog2(N_STEPS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [WORD_W-1:0] rword
);
   logic [WORD_W-1:0] words [N_STEPS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N_STEPS; i++) words[i] <= '0;
      end else if (we) begin
         words[widx] <= wdata;
      end
   end

   assign rword = words[ridx];
endmodule

// File: rtl/lut_addr_router.sv
module lut_addr_router #(
   parameter int N_IN   = 4,
   parameter int N_TMP  = 8,
   parameter int ADDR_W = 6,
   parameter int SEL_W  = 4,
   localparam int SRC_N = 2 ** SEL_W
) (
   input  logic [N_IN-1:0]         in_vec,
   input  logic [N_TMP-1:0]        tmp_vec,
   input  logic [ADDR_W*SEL_W-1:0] sel_vec,
   output logic [ADDR_W-1:0]       addr_o
);
   logic [SRC_N-1:0] src;

   if (N_IN + N_TMP > SRC_N) begin : g_bad_sel
      $error("lut_addr_router: SEL_W too narrow for all sources");
   end

   // sources: inputs at the bottom, temporaries next, zeros above
   always_comb begin
      src = '0;
      src[N_IN-1:0]    = in_vec;
      src[N_IN+:N_TMP] = tmp_vec;
   end

   for (genvar j = 0; j < ADDR_W; j++) begin : g_bit
      logic [SEL_W-1:0] code;
      assign code      = sel_vec[j*SEL_W +: SEL_W];
      assign addr_o[j] = src[code];
   end
endmodule

// File: rtl/lut_eval_engine.sv
module lut_eval_engine
   import lut_pkg::*;
#(
   parameter int N_IN      = 4,
   parameter int N_TMP     = 8,
   parameter int ADDR_W    = 6,
   parameter int OUT_W     = 4,
   parameter int MAX_STEPS = 8,
   localparam int SEL_W    = $clog2(N_IN + N_TMP),
   localparam int N_SLICE  = N_TMP / OUT_W,
   localparam int SLICE_W  = (N_SLICE > 1) ? $clog2(N_SLICE) : 1,
   localparam int STEP_W   = $clog2(MAX_STEPS),
   localparam int TBL_AW   = STEP_W + ADDR_W,
   localparam int SEL_BITS = ADDR_W * SEL_W,
   localparam int WORD_W   = SEL_BITS + 1 + SLICE_W,
   localparam int CFG_DW   = (WORD_W > OUT_W) ? WORD_W : OUT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [TBL_AW-1:0] cfg_addr,
   input  logic [CFG_DW-1:0] cfg_data,
   input  logic              start,
   input  logic [N_IN-1:0]   din,
   output logic              done,
   output logic [OUT_W-1:0]  dout
);
   if (N_TMP % OUT_W != 0) begin : g_bad_slice
      $error("lut_eval_engine: N_TMP must be a multiple of OUT_W");
   end
   if (MAX_STEPS < 2 || (1 << STEP_W) != MAX_STEPS) begin : g_bad_steps
      $error("lut_eval_engine: MAX_STEPS must be a power of two >= 2");
   end
   if (N_TMP < OUT_W) begin : g_bad_tmp
      $error("lut_eval_engine: N_TMP must hold at least one output row");
   end

   eng_state_t        state;
   logic [STEP_W-1:0] step_q;
   logic [N_TMP-1:0]  tmp_q;
   logic [N_IN-1:0]   in_q;

   logic [WORD_W-1:0]   step_word;
   logic [SEL_BITS-1:0] step_sel;
   logic                step_last;
   logic [SLICE_W-1:0]  step_slice;
   logic [ADDR_W-1:0]   route_addr;
   logic [OUT_W-1:0]    tbl_rdata;
   logic                idle_w;
   logic                tbl_we;
   logic                word_we;

   assign idle_w  = (state == ST_IDLE);
   assign tbl_we  = cfg_we && idle_w && (cfg_sel == CFG_TABLE);
   assign word_we = cfg_we && idle_w && (cfg_sel == CFG_STEP);

   lut_table_mem #(
      .DATA_W (OUT_W),
      .DEPTH  (MAX_STEPS << ADDR_W)
   ) u_tbl (
      .clk   (clk),
      .we    (tbl_we),
      .waddr (cfg_addr),
      .wdata (cfg_data[OUT_W-1:0]),
      .raddr ({step_q, route_addr}),
      .rdata (tbl_rdata)
   );

   lut_step_store #(
      .WORD_W  (WORD_W),
      .N_STEPS (MAX_STEPS)
   ) u_steps (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (word_we),
      .widx  (cfg_addr[STEP_W-1:0]),
      .wdata (cfg_data[WORD_W-1:0]),
      .ridx  (step_q),
      .rword (step_word)
   );

   assign step_sel   = step_word[SEL_BITS-1:0];
   assign step_last  = step_word[SEL_BITS];
   assign step_slice = step_word[SEL_BITS+1 +: SLICE_W];

   lut_addr_router #(
      .N_IN   (N_IN),
      .N_TMP  (N_TMP),
      .ADDR_W (ADDR_W),
      .SEL_W  (SEL_W)
   ) u_route (
      .in_vec  (in_q),
      .tmp_vec (tmp_q),
      .sel_vec (step_sel),
      .addr_o  (route_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         step_q <= '0;
         tmp_q  <= '0;
         in_q   <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  in_q   <= din;
                  tmp_q  <= '0;
                  step_q <= '0;
                  state  <= ST_ADDR;
               end
            end
            ST_ADDR: state <= ST_WRITE;
            ST_WRITE: begin
               for (int s = 0; s < N_SLICE; s++) begin
                  if (step_slice == SLICE_W'(s)) tmp_q[s*OUT_W +: OUT_W] <= tbl_rdata;
               end
               if (step_last || step_q == STEP_W'(MAX_STEPS - 1)) begin
                  state <= ST_DONE;
               end else begin
                  step_q <= step_q + 1'b1;
                  state  <= ST_ADDR;
               end
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign done = (state == ST_DONE);
   assign dout = tmp_q[OUT_W-1:0];

   // R4
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   addr_to_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR) |=> (state == ST_WRITE));

   // R2
   start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_w && start) |=> (tmp_q == '0 && in_q == $past(din)));

   // R11
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!idle_w) |=> $stable(in_q));

   // R8
   step_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WRITE && step_q == STEP_W'(MAX_STEPS - 1)) |=> done);

   // R9
   dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE || (idle_w && !start)) |=> $stable(dout));
endmodule

// File: tb/lut_eval_engine_tb.sv
module lut_eval_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [8:0]  cfg_addr = '0;
   logic [25:0] cfg_data = '0;
   logic        start = 1'b0;
   logic [3:0]  din = '0;
   logic        done;
   logic [3:0]  dout;

   int n_tot = 0;
   int n_bad = 0;
   int cyc = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   lut_eval_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .start(start), .din(din),
      .done(done), .dout(dout)
   );

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         n_tot++; n_bad++;
         $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tot++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
      end
   endtask

   function automatic logic [3:0] row_val(int prog, int st, logic [5:0] a);
      logic [3:0] r;
      logic [5:0] used;
      int cnt;
      cnt = a[0] + a[1] + a[2] + a[3];
      r = '0; used = '1;
      if (prog == 0 && st == 0) begin
         used = 6'b000011; r = {2'b0, a[0] & a[1], a[0] ^ a[1]};
      end else if (prog == 0) begin
         used = 6'b001111;
         r = {1'b0, (a[0]&a[1]) | (a[0]&a[2]) | (a[1]&a[2]), a[0]^a[1]^a[2], a[3]};
      end else if (prog == 1 && st == 0) begin
         used = 6'b001111; r = {2'b0, ^a[3:0], cnt >= 2};
      end else if (prog == 1 && st == 1) begin
         used = 6'b000111; r = {a[2] | a[0], ~a[1], a[1] & a[0], a[0] ^ a[2]};
      end else if (prog == 1) begin
         used = 6'b000001; r = {4{~a[0]}};
      end else begin
         r = 4'((3 * a[3:0] + a[5:4] + 1));
      end
      // R5: rows reached only through nonzero unused bits carry a wrong value
      if ((a & ~used) != 0) r = r ^ 4'b0101;
      return r;
   endfunction

   function automatic logic [25:0] step_word(int prog, int st);
      case (prog)
         0: return (st == 0) ? {1'b1, 1'b0, 24'hFFFF20} : {1'b0, 1'b1, 24'hFF8931};
         1: return (st == 0) ? {1'b1, 1'b0, 24'hFF3210} :
                   (st == 1) ? {1'b0, 1'b0, 24'hFFF098} : {1'b1, 1'b1, 24'hFFFFF4};
         default: return {1'b0, 1'b0, 24'h107654};
      endcase
   endfunction

   function automatic int n_steps(int prog);
      return (prog == 0) ? 2 : (prog == 1) ? 3 : 8;
   endfunction

   function automatic logic [3:0] expect_out(int prog, logic [3:0] x);
      logic m, p;
      logic [3:0] t;
      if (prog == 0) return 4'(x[1:0] + x[3:2]);
      if (prog == 1) begin
         m = (x[0] + x[1] + x[2] + x[3]) >= 2;
         p = ^x;
         return {x[0] | m, ~p, p & m, m ^ x[0]};
      end
      t = '0;
      for (int k = 0; k < 8; k++) t = 4'(3 * t + x[1:0] + 1);
      return t;
   endfunction

   task automatic cfg_write(input logic sel, input int addr, input logic [25:0] data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_addr = 9'(addr); cfg_data = data;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load(input int prog);
      for (int st = 0; st < n_steps(prog); st++) begin
         for (int a = 0; a < 64; a++)
            cfg_write(1'b0, st * 64 + a, {22'b0, row_val(prog, st, 6'(a))});
         cfg_write(1'b1, st, step_word(prog, st));
      end
   endtask

   task automatic run(input int prog, input logic [3:0] x, input bit inject);
      int cnt;
      logic [3:0] e;
      e = expect_out(prog, x);
      @(negedge clk);
      din = x; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0; din = ~x;
      cnt = 1;
      if (inject) begin
         // R10, R11: step word rewrite and a second start while busy
         start = 1'b1; cfg_we = 1'b1; cfg_sel = 1'b1; cfg_addr = 9'd1; cfg_data = '0;
         @(posedge clk);
         @(negedge clk);
         start = 1'b0; cfg_we = 1'b0;
         cnt = 2;
      end
      while (!done && cnt < 64) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
      end
      // R3 R8 latency, R11 timing unchanged by busy start
      chk(cnt == 2 * n_steps(prog) + 1, inject ? "R3/R8/R11 latency" : "R3/R8 latency",
          cnt, 2 * n_steps(prog) + 1);
      // R2 R5 R6 R7 R10 result
      chk(dout == e, inject ? "R10/R11 result" : "R2/R5/R6/R7 result", dout, e);
      @(negedge clk);
      chk(done == 1'b0, "R4 done width", done, 0);
      chk(dout == e, "R9 hold", dout, e);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(dout == 4'h0, "R1 dout", dout, 0);
      for (int prog = 0; prog < 3; prog++) begin
         load(prog); // R12
         for (int x = 0; x < 16; x++) run(prog, 4'(x), 1'b0);
         for (int k = 0; k < 12; k++) run(prog, 4'($urandom % 16), 1'($urandom % 2));
         run(prog, 4'hF, 1'b1);
      end
      summary();
   end
endmodule